// File: doc/BRIEF.md
# Multi-Plane Masked Pixel Write ALU

This block applies a raster operation to one byte address of a frame buffer held as four bit-planes. The planes share the address and are told apart by a plane index on the memory port. When triggered, it walks the planes that are not disabled in ascending order. For each one it reads the stored byte, merges it with that plane's colour under a shared 8-bit preserve mask, and writes the result back to the same place.

The operation is one of pixel set, OR, AND, XOR or invert, chosen by a command register. A colour register holds one bit per plane: a set bit stands for an all-ones byte and a clear bit for an all-zeros byte. A 1 in the mask register protects the matching bit in every plane. A bank-disable register removes individual planes from the operation altogether.

The four registers are loaded through a small write port with a 2-bit select. The memory port has a one-cycle read latency. The busy output shows when an operation is still in progress.

Top module: `plane_rop_alu`

## Requirements
- R1: After reset the block is idle, with busy, mem_rd and mem_wr low. The command register resets to pixel set (code 0), and the colour, mask and bank-disable registers all reset to zero. An operation issued straight after reset therefore rewrites every bit of every plane.
- R2: When bit i of the bank-disable register (select 3, data bits 3:0) is 1, plane i is neither read nor written, and its contents stay unchanged.
- R3: Where a bit of the mask register (select 2) is 1, that bit keeps its old value in every plane and in every mode.
- R4: Enabled planes are visited in ascending index order. Each visit is one cycle with mem_rd high, then the next cycle with mem_wr high, at the same address and plane. mem_rdata is taken as valid in the cycle after mem_rd.
- R5: Pixel set (command code 0, select 0, data bits 2:0): each unmasked bit becomes 1 if the plane's colour bit (select 1, data bit i for plane i) is set, and 0 otherwise.
- R6: OR (code 1), AND (code 2) and XOR (code 3) combine the old byte with the plane's colour byte using that operator, on unmasked bits only.
- R7: Invert (code 4) inverts the unmasked bits of the old byte and ignores the colour register.
- R8: A trigger taken while idle raises busy on the next cycle. With N enabled planes, busy stays high for exactly 2N cycles, ending with the last write. A trigger while busy is ignored.
- R9: If every plane is disabled, or the command code is 5, 6 or 7, busy is high for exactly one cycle and there is no memory access.
- R10: A register write while busy, or in the same cycle as an accepted trigger, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 colour, 2 mask, 3 bank disable |
| reg_wdata | input | DW | Register write data |
| start | input | 1 | Operation trigger |
| addr | input | AW | Frame-buffer byte address for the operation |
| busy | output | 1 | Operation in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_plane | output | log2(NPLANES) | Plane index of the access |
| mem_wdata | output | DW | Merged byte to write |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd |

## Verification
The assertions assume the memory returns its read data exactly one cycle after mem_rd, with no wait states. The bench memory model is a registered read of a plane array, so it meets that assumption. The assertions also assume that start and register writes are only sampled at clock edges. The bench changes these inputs two time units after a rising edge and holds each one for a whole cycle. It also deliberately issues triggers and register writes while busy, so that the ignore rules are exercised against inputs that the assertions still accept as legal.

// File: rtl/plane_rop_pkg.sv
package plane_rop_pkg;

    typedef enum logic [2:0] {
        ROP_PSET = 3'd0,
        ROP_OR   = 3'd1,
        ROP_AND  = 3'd2,
        ROP_XOR  = 3'd3,
        ROP_NOT  = 3'd4
    } rop_op_e;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_COLOR = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_BDIS  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_READ   = 2'd1,
        SQ_WRITE  = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/rop_regs.sv
module rop_regs
    import plane_rop_pkg::*;
#(
    parameter int NPLANES = 4,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic [DW-1:0]      wdata,
    input  logic               hold,
    output logic [2:0]         cmd_q,
    output logic [NPLANES-1:0] color_q,
    output logic [DW-1:0]      mask_q,
    output logic [NPLANES-1:0] bdis_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= ROP_PSET;
            color_q <= '0;
            mask_q  <= '0;
            bdis_q  <= '0;
        end else if (we && !hold) begin
            case (reg_sel_e'(sel))
                SEL_CMD:   cmd_q   <= wdata[2:0];
                SEL_COLOR: color_q <= wdata[NPLANES-1:0];
                SEL_MASK:  mask_q  <= wdata;
                SEL_BDIS:  bdis_q  <= wdata[NPLANES-1:0];
                default:   ;
            endcase
        end
    end

    // R10: an operation sees constant register contents
    a_r10_regs_frozen: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(cmd_q) && $stable(color_q) && $stable(mask_q) && $stable(bdis_q)));

endmodule

// File: rtl/rop_merge.sv
module rop_merge
    import plane_rop_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]    op,
    input  logic          color_bit,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] old_byte,
    output logic [DW-1:0] new_byte
);

    logic [DW-1:0] col_byte;
    logic [DW-1:0] raw;

    assign col_byte = {DW{color_bit}};

    always_comb begin
        case (rop_op_e'(op))
            ROP_PSET: raw = col_byte;
            ROP_OR:   raw = old_byte | col_byte;
            ROP_AND:  raw = old_byte & col_byte;
            ROP_XOR:  raw = old_byte ^ col_byte;
            ROP_NOT:  raw = ~old_byte;
            default:  raw = old_byte;
        endcase
        new_byte = (old_byte & mask) | (raw & ~mask);
    end

endmodule

// File: rtl/rop_sequencer.sv
module rop_sequencer
    import plane_rop_pkg::*;
#(
    parameter int NPLANES = 4,
    parameter int AW      = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [AW-1:0]              addr,
    input  logic                       op_ok,
    input  logic [NPLANES-1:0]         bdis,
    output logic                       busy,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic [AW-1:0]              mem_addr,
    output logic [$clog2(NPLANES)-1:0] mem_plane
);

    localparam int PW = $clog2(NPLANES);

    seq_state_e    st;
    logic [PW-1:0] plane_q;
    logic [AW-1:0] addr_q;
    logic          first_any, next_any;
    logic [PW-1:0] first_idx, next_idx;

    always_comb begin
        first_any = 1'b0;
        first_idx = '0;
        next_any  = 1'b0;
        next_idx  = '0;
        for (int i = NPLANES - 1; i >= 0; i--) begin
            if (!bdis[i]) begin
                first_any = 1'b1;
                first_idx = PW'(i);
                if (i > int'(plane_q)) begin
                    next_any = 1'b1;
                    next_idx = PW'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            plane_q <= '0;
            addr_q  <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    addr_q <= addr;
                    if (op_ok && first_any) begin
                        st      <= SQ_READ;
                        plane_q <= first_idx;
                    end else begin
                        st <= SQ_FINISH;
                    end
                end
                SQ_READ:  st <= SQ_WRITE;
                SQ_WRITE: if (next_any) begin
                    st      <= SQ_READ;
                    plane_q <= next_idx;
                end else begin
                    st <= SQ_IDLE;
                end
                default:  st <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (st != SQ_IDLE);
    assign mem_rd    = (st == SQ_READ);
    assign mem_wr    = (st == SQ_WRITE);
    assign mem_addr  = addr_q;
    assign mem_plane = plane_q;

    a_r4_write_after_read: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($past(mem_rd) && $stable(mem_plane) && $stable(mem_addr)));

    a_r4_planes_ascend: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_wr)) |-> (mem_plane > $past(mem_plane)));

    a_r8_trigger_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r9_idle_cycle_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rd && !mem_wr) |=> !busy);

endmodule

// File: rtl/plane_rop_alu.sv
module plane_rop_alu
    import plane_rop_pkg::*;
#(
    parameter int NPLANES = 4,
    parameter int DW      = 8,
    parameter int AW      = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_we,
    input  logic [1:0]                 reg_sel,
    input  logic [DW-1:0]              reg_wdata,
    input  logic                       start,
    input  logic [AW-1:0]              addr,
    output logic                       busy,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic [AW-1:0]              mem_addr,
    output logic [$clog2(NPLANES)-1:0] mem_plane,
    output logic [DW-1:0]              mem_wdata,
    input  logic [DW-1:0]              mem_rdata
);

    logic [2:0]         cmd_q;
    logic [NPLANES-1:0] color_q;
    logic [DW-1:0]      mask_q;
    logic [NPLANES-1:0] bdis_q;
    logic               hold;

    assign hold = busy | start;

    rop_regs #(.NPLANES(NPLANES), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .hold(hold), .cmd_q(cmd_q), .color_q(color_q), .mask_q(mask_q), .bdis_q(bdis_q)
    );

    rop_sequencer #(.NPLANES(NPLANES), .AW(AW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .op_ok(op_known(cmd_q)),
        .bdis(bdis_q), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_plane(mem_plane)
    );

    rop_merge #(.DW(DW)) u_merge (
        .op(cmd_q), .color_bit(color_q[mem_plane]), .mask(mask_q),
        .old_byte(mem_rdata), .new_byte(mem_wdata)
    );

    a_r2_disabled_plane_quiet: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> !bdis_q[mem_plane]);

    a_r3_masked_bits_kept: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (((mem_wdata ^ mem_rdata) & mask_q) == '0));

endmodule

// File: tb/sim_plane_rop_alu.sv
module sim_plane_rop_alu;

    localparam int NP = 4;
    localparam int DW = 8;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          busy, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_plane;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #5 clk = ~clk;

    plane_rop_alu #(.NPLANES(NP), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .start(start), .addr(addr), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_plane(mem_plane), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [7:0] mem  [NP][16];
    logic [7:0] refm [NP][16];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_plane][mem_addr[3:0]];
        if (mem_wr) mem[mem_plane][mem_addr[3:0]] <= mem_wdata;
    end

    typedef struct {
        logic       busy;
        logic       rd;
        logic       wr;
        int         plane;
        int         adr;
        logic [7:0] wd;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic mon_on = 1'b0;
    logic [2:0] r_cmd = 3'd0;
    logic [3:0] r_color = 4'd0;
    logic [7:0] r_mask = 8'd0;
    logic [3:0] r_dis = 4'd0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] calc(input logic [2:0] op, input logic cb,
                                        input logic [7:0] m, input logic [7:0] old);
        logic [7:0] c;
        logic [7:0] f;
        c = cb ? 8'hFF : 8'h00;
        case (op)
            3'd0: f = c;
            3'd1: f = old | c;
            3'd2: f = old & c;
            3'd3: f = old ^ c;
            default: f = ~old;
        endcase
        // R3: protected bits come from the old byte
        return (old & m) | (f & ~m);
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            exp_t e;
            if (q.size() > 0) e = q.pop_front();
            else e = '{busy: 1'b0, rd: 1'b0, wr: 1'b0, plane: 0, adr: 0, wd: 8'h00, tag: "R8"};
            chk({e.tag, " busy"}, int'(busy), int'(e.busy));
            chk("R4 mem_rd", int'(mem_rd), int'(e.rd));
            chk("R4 mem_wr", int'(mem_wr), int'(e.wr));
            if (e.rd || e.wr) begin
                chk("R4 plane", int'(mem_plane), e.plane);
                chk("R4 address", int'(mem_addr), e.adr);
            end
            if (e.wr) chk({e.tag, " write data"}, int'(mem_wdata), int'(e.wd));
        end
    end

    task automatic wreg(input logic [1:0] s, input logic [7:0] d, input bit applies);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
        if (applies) begin
            case (s)
                2'd0: r_cmd = d[2:0];
                2'd1: r_color = d[3:0];
                2'd2: r_mask = d;
                default: r_dis = d[3:0];
            endcase
        end
    endtask

    task automatic trigger(input int a);
        bit any;
        string t;
        @(posedge clk); #2;
        start = 1'b1; addr = AW'(a);
        @(posedge clk); #2;
        start = 1'b0;
        any = 0;
        case (r_cmd)
            3'd0: t = "R5";
            3'd1, 3'd2, 3'd3: t = "R6";
            default: t = "R7";
        endcase
        if (r_cmd <= 3'd4) begin
            for (int p = 0; p < NP; p++) begin
                if (!r_dis[p]) begin
                    logic [7:0] nv;
                    any = 1;
                    nv = calc(r_cmd, r_color[p], r_mask, refm[p][a]);
                    q.push_back('{busy: 1'b1, rd: 1'b1, wr: 1'b0, plane: p, adr: a, wd: 8'h00, tag: "R8"});
                    q.push_back('{busy: 1'b1, rd: 1'b0, wr: 1'b1, plane: p, adr: a, wd: nv, tag: t});
                    refm[p][a] = nv;
                end
            end
        end
        if (!any)
            q.push_back('{busy: 1'b1, rd: 1'b0, wr: 1'b0, plane: 0, adr: a, wd: 8'h00, tag: "R9"});
    endtask

    task automatic wait_idle();
        do begin
            @(posedge clk); #2;
        end while (q.size() != 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NP; p++)
            for (int a = 0; a < 16; a++) begin
                mem[p][a]  = 8'(p * 37 + a * 11 + 5);
                refm[p][a] = 8'(p * 37 + a * 11 + 5);
            end
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 busy", int'(busy), 0);
        chk("R1 mem_rd", int'(mem_rd), 0);
        chk("R1 mem_wr", int'(mem_wr), 0);
        mon_on = 1'b1;

        // R1: reset registers: pixel set, zero colour, zero mask, all planes
        trigger(1); wait_idle();

        // R5: pixel set with partial mask
        wreg(2'd1, 8'h0A, 1); wreg(2'd2, 8'h0F, 1);
        trigger(2); wait_idle();
        // R6: OR, AND, XOR
        wreg(2'd0, 8'h01, 1); wreg(2'd1, 8'h05, 1); wreg(2'd2, 8'hC3, 1);
        trigger(3); wait_idle();
        wreg(2'd0, 8'h02, 1); wreg(2'd1, 8'h03, 1); wreg(2'd2, 8'h18, 1);
        trigger(4); wait_idle();
        wreg(2'd0, 8'h03, 1); wreg(2'd1, 8'h0F, 1); wreg(2'd2, 8'h81, 1);
        trigger(5); wait_idle();
        // R7: invert ignores colour
        wreg(2'd0, 8'h04, 1); wreg(2'd1, 8'h0A, 1); wreg(2'd2, 8'h0F, 1);
        trigger(6); wait_idle();
        wreg(2'd2, 8'h00, 1);
        trigger(6); wait_idle();

        // R2: bank disable
        wreg(2'd0, 8'h00, 1); wreg(2'd1, 8'h0F, 1);
        wreg(2'd3, 8'h05, 1);
        trigger(7); wait_idle();
        wreg(2'd3, 8'h0E, 1);
        trigger(8); wait_idle();
        // R9: all disabled, then unknown code
        wreg(2'd3, 8'h0F, 1);
        trigger(9); wait_idle();
        wreg(2'd3, 8'h00, 1); wreg(2'd0, 8'h06, 1);
        trigger(10); wait_idle();
        wreg(2'd0, 8'h07, 1);
        trigger(10); wait_idle();

        // R8: trigger while busy ignored; R10: register writes while busy ignored
        wreg(2'd0, 8'h03, 1); wreg(2'd1, 8'h06, 1); wreg(2'd2, 8'h30, 1);
        trigger(11);
        @(posedge clk); #2 start = 1'b1; addr = AW'(12);
        @(posedge clk); #2 start = 1'b0;
        wait_idle();
        trigger(13);
        wreg(2'd2, 8'hFF, 0);
        wreg(2'd0, 8'h04, 0);
        wait_idle();
        trigger(14); wait_idle();
        // R10: write in the same cycle as the trigger
        @(posedge clk); #2;
        start = 1'b1; addr = AW'(15); reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 8'hFF;
        @(posedge clk); #2;
        start = 1'b0; reg_we = 1'b0;
        for (int p = 0; p < NP; p++) begin
            logic [7:0] nv;
            nv = calc(r_cmd, r_color[p], r_mask, refm[p][15]);
            q.push_back('{busy: 1'b1, rd: 1'b1, wr: 1'b0, plane: p, adr: 15, wd: 8'h00, tag: "R10"});
            q.push_back('{busy: 1'b1, rd: 1'b0, wr: 1'b1, plane: p, adr: 15, wd: nv, tag: "R10"});
            refm[p][15] = nv;
        end
        wait_idle();
        repeat (3) @(posedge clk);

        // R2: every stored byte matches the reference, including skipped planes
        for (int p = 0; p < NP; p++)
            for (int a = 0; a < 16; a++)
                chk("R2 memory contents", int'(mem[p][a]), int'(refm[p][a]));

        finish_run();
    end

endmodule